// File: doc/BRIEF.md
# Five-Operation Bit-Sliced ALU

A combinational arithmetic and logic unit of parameterised width (8 bits by default). It is built as a column of identical slices joined by a ripple carry. Each slice is a NAND-gate full adder with two more result taps added. Small input-forcing muxes in front of the gates turn the adder's own gates into AND, OR and inverter paths. No separate logic unit is instantiated.

Three control lines select the operation: `op0_i`, `op1_i` and `sub_i`. A fourth select steers the operand-forcing mux inside every slice. It is not an input: it is derived as `op0_i | op1_i`. The block computes addition, two's-complement subtraction, bitwise AND, bitwise OR, and the bitwise inverse of operand A. A carry out is reported for the two arithmetic operations.

Top module: `alu5_top`

## Requirements
- R1: With {op0_i, op1_i, sub_i} = 0,1,0 (ADD), result_o equals (a_i + b_i) mod 2^WIDTH, and carry_o equals bit WIDTH of the full sum.
- R2: With {op0_i, op1_i, sub_i} = 0,1,1 (SUB), result_o equals (a_i - b_i) mod 2^WIDTH. This is formed as a_i + ~b_i + 1, so carry_o is 1 exactly when a_i >= b_i.
- R3: With {op0_i, op1_i, sub_i} = 0,0,0 (AND), result_o equals a_i & b_i and carry_o is 0.
- R4: With {op0_i, op1_i, sub_i} = 1,1,0 (OR), result_o equals a_i | b_i and carry_o is 0.
- R5: With {op0_i, op1_i, sub_i} = 1,0,0 (NOT), result_o equals ~a_i and carry_o is 0. The value of b_i has no effect on either output.
- R6: The otherwise unused code {op0_i, op1_i, sub_i} = 1,0,1 gives the same outputs as NOT: result_o = ~a_i and carry_o = 0.
- R7: The carry ripples through every slice. 0xFF + 0x01 gives result 0x00 with carry 1. 0x00 - 0x01 gives result 0xFF with carry 0. 0x80 - 0x80 gives result 0x00 with carry 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B |
| op0_i | input | 1 | Control line 0, low select of the output mux |
| op1_i | input | 1 | Control line 1, high select of the output mux |
| sub_i | input | 1 | Subtract control: inverts B and sets the carry in |
| result_o | output | WIDTH | Operation result |
| carry_o | output | 1 | Carry out of the top slice for ADD/SUB, 0 otherwise |

## Verification
Whenever the inputs change, assertions in the top module compare the outputs against the arithmetic identities for ADD and SUB. They also check that carry is zero for the logic codes, and that the NOT and spare codes invert A. The bench is what shows that B is ignored under NOT and that the spare code matches NOT. It does this by sweeping every A and B pair for all six codes. The same sweep covers the specific ripple patterns across all slices.

// File: rtl/alu5_pkg.sv
package alu5_pkg;
  typedef struct packed {
    logic op0;
    logic op1;
    logic op2;
    logic sub;
  } alu_sel_t;

  typedef enum logic [1:0] {
    TAP_AND_NOT_A = 2'b00,
    TAP_AND_NOT_B = 2'b01,
    TAP_SUM       = 2'b10,
    TAP_OR        = 2'b11
  } tap_sel_e;
endpackage

// File: rtl/alu5_ctrl.sv
module alu5_ctrl
  import alu5_pkg::*;
(
  input  logic     op0_i,
  input  logic     op1_i,
  input  logic     sub_i,
  output alu_sel_t sel_o,
  output logic     cin_o,
  output logic     cout_en_o
);
  always_comb begin
    sel_o.op0 = op0_i;
    sel_o.op1 = op1_i;
    sel_o.op2 = op0_i | op1_i;  // forcing mux passes B only for AND
    sel_o.sub = sub_i;
  end

  assign cin_o     = sub_i;
  assign cout_en_o = op1_i & ~op0_i;  // sum tap selected
endmodule

// File: rtl/alu5_slice.sv
module alu5_slice
  import alu5_pkg::*;
(
  input  logic     a_i,
  input  logic     b_i,
  input  logic     c_i,
  input  alu_sel_t sel_i,
  output logic     r_o,
  output logic     c_o
);
  logic bx, bf, g_ab, ra, rb, rc;
  logic na, nb;
  logic n1, n2, n3, h, n5, n6, n7;

  assign bx = sel_i.sub ? ~b_i : b_i;

  // RA: shared NAND, B forced high by op2 -> inverter for NOT
  assign bf   = sel_i.op2 ? 1'b1 : bx;
  assign g_ab = ~(a_i & bf);
  assign ra   = sel_i.op0 ? g_ab : ~g_ab;

  // RB: op0 turns input NANDs into inverters, OR by De Morgan
  assign na = ~(a_i & sel_i.op0);
  assign nb = ~(b_i & sel_i.op0);
  assign rb = ~(na & nb);

  // RC: nine-NAND full adder
  assign n1  = ~(a_i & bx);
  assign n2  = ~(a_i & n1);
  assign n3  = ~(bx & n1);
  assign h   = ~(n2 & n3);
  assign n5  = ~(h & c_i);
  assign n6  = ~(h & n5);
  assign n7  = ~(c_i & n5);
  assign rc  = ~(n6 & n7);
  assign c_o = ~(n1 & n5);

  always_comb begin
    unique case (tap_sel_e'({sel_i.op1, sel_i.op0}))
      TAP_AND_NOT_A: r_o = ra;
      TAP_AND_NOT_B: r_o = ra;
      TAP_SUM:       r_o = rc;
      default:       r_o = rb;
    endcase
  end
endmodule

// File: rtl/alu5_top.sv
module alu5_top
  import alu5_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             op0_i,
  input  logic             op1_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] result_o,
  output logic             carry_o
);
  localparam int CW = WIDTH + 1;

  alu_sel_t      sel;
  logic          cin, cout_en;
  logic [CW-1:0] chain;

  alu5_ctrl u_ctrl (
    .op0_i    (op0_i),
    .op1_i    (op1_i),
    .sub_i    (sub_i),
    .sel_o    (sel),
    .cin_o    (cin),
    .cout_en_o(cout_en)
  );

  assign chain[0] = cin;

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    alu5_slice u_slice (
      .a_i  (a_i[i]),
      .b_i  (b_i[i]),
      .c_i  (chain[i]),
      .sel_i(sel),
      .r_o  (result_o[i]),
      .c_o  (chain[i+1])
    );
  end

  assign carry_o = cout_en & chain[WIDTH];

  logic [CW-1:0] ref_add, ref_sub;
  assign ref_add = {1'b0, a_i} + {1'b0, b_i};
  assign ref_sub = {1'b0, a_i} + {1'b0, ~b_i} + CW'(1);

  always_comb begin
    if ({op0_i, op1_i, sub_i} == 3'b010)
      assert_add_R1: assert ({carry_o, result_o} == ref_add);
    if ({op0_i, op1_i, sub_i} == 3'b011)
      assert_sub_R2: assert ({carry_o, result_o} == ref_sub);
    if ({op0_i, op1_i, sub_i} == 3'b000)
      assert_and_R3: assert (result_o == (a_i & b_i) && !carry_o);
    if ({op0_i, op1_i, sub_i} == 3'b110)
      assert_or_R4: assert (result_o == (a_i | b_i) && !carry_o);
    if ({op0_i, op1_i} == 2'b10)
      assert_not_R5_R6: assert (result_o == ~a_i && !carry_o);
  end
endmodule

// File: tb/alu5_top_tb.sv
module alu5_top_tb;
  localparam int  WIDTH    = 8;
  localparam time CLK_PER  = 10;
  localparam int  WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #(CLK_PER/2) clk = ~clk;

  logic [WIDTH-1:0] a, b, res;
  logic op0, op1, sub, cy;
  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  alu5_top #(.WIDTH(WIDTH)) u_dut (
    .a_i(a), .b_i(b), .op0_i(op0), .op1_i(op1), .sub_i(sub),
    .result_o(res), .carry_o(cy)
  );

  task automatic check(input string req, input logic [WIDTH:0] exp);
    n_tests++;
    if ({cy, res} !== exp) begin
      n_fail++;
      $display("FAIL %s a=%h b=%h code=%b%b%b got {c,r}=%h exp=%h",
               req, a, b, op0, op1, sub, {cy, res}, exp);
    end
  endtask

  task automatic apply(input logic [2:0] code, input logic [WIDTH-1:0] av,
                       input logic [WIDTH-1:0] bv);
    {op0, op1, sub} = code;
    a = av;
    b = bv;
    #1;
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [WIDTH:0] e;
    {op0, op1, sub} = 3'b000;
    a = '0;
    b = '0;
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R3 idle", '0);

    // R7 ripple corners
    apply(3'b010, 8'hFF, 8'h01); check("R7 add ripple", 9'h100);
    apply(3'b011, 8'h00, 8'h01); check("R7 sub borrow", 9'h0FF);
    apply(3'b011, 8'h80, 8'h80); check("R7 sub equal", 9'h100);
    apply(3'b010, 8'hFF, 8'hFF); check("R7 add max", 9'h1FE);

    for (int ai = 0; ai < (1 << WIDTH); ai++) begin
      @(negedge clk);
      for (int bi = 0; bi < (1 << WIDTH); bi++) begin
        apply(3'b010, ai[WIDTH-1:0], bi[WIDTH-1:0]);
        check("R1 add", (WIDTH+1)'(ai + bi));
        apply(3'b011, ai[WIDTH-1:0], bi[WIDTH-1:0]);
        e[WIDTH-1:0] = WIDTH'(ai - bi);
        e[WIDTH]     = (ai >= bi);
        check("R2 sub", e);
        apply(3'b000, ai[WIDTH-1:0], bi[WIDTH-1:0]);
        check("R3 and", {1'b0, WIDTH'(ai & bi)});
        apply(3'b110, ai[WIDTH-1:0], bi[WIDTH-1:0]);
        check("R4 or", {1'b0, WIDTH'(ai | bi)});
        apply(3'b100, ai[WIDTH-1:0], bi[WIDTH-1:0]);
        check("R5 not", {1'b0, ~ai[WIDTH-1:0]});
        apply(3'b101, ai[WIDTH-1:0], bi[WIDTH-1:0]);
        check("R6 spare", {1'b0, ~ai[WIDTH-1:0]});
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule